// File: doc/BRIEF.md
# Near Branch Resolver

This block settles the outcome of a 16-bit near control transfer in a real-mode core. For each request it takes the address of the next instruction, a signed displacement, a transfer kind, a condition code, the arithmetic flags, the count register and the address-size bit. One cycle later it reports whether the transfer is taken, the instruction pointer to continue from, a new count value with its write enable, and a general-protection fault request.

Every taken target is checked against the code-segment limit, whatever the processor mode. A loop decrement is committed only when the transfer cannot fault, so a faulting loop leaves the count exactly as it was. The flags are only read. Decode, the flag-producing arithmetic and protected-mode checks live elsewhere.

Top module: `near_branch_resolver`

## Requirements
- R1: The target is `cur_ip + disp` modulo 2^16. A taken transfer reports it on `res_ip`, with wrap-around in both directions.
- R2: A would-be-taken transfer whose zero-extended target exceeds `cs_limit` sets `gp_fault`, clears `res_taken` and returns `cur_ip` on `res_ip`. A target equal to the limit is legal.
- R3: For kind 1, `req_cond` bits [3:1] pick a flag test: 0 OF, 1 CF, 2 ZF, 3 CF|ZF, 4 SF, 5 PF, 6 SF!=OF, 7 ZF|(SF!=OF). Bit 0 set inverts the test.
- R4: Kind 2 (jump if count zero) tests all 32 bits of `cnt_in` when `addr32`=1, and only bits [15:0] otherwise. It never writes the count.
- R5: Kinds 3, 4 and 5 decrement the count and are taken when the decremented value is nonzero. Kind 4 also needs ZF=1, and kind 5 also needs ZF=0. Kind 0 is always taken.
- R6: With `addr32`=0 a loop changes only bits [15:0], which wrap from 0 to 0xFFFF, and bits [31:16] pass through. With `addr32`=1 all 32 bits decrement.
- R7: A loop that faults has `cnt_we`=0. A loop that does not fault has `cnt_we`=1 whether taken or not.
- R8: A transfer that is not taken returns `cur_ip` on `res_ip` and never faults, whatever its target.
- R9: Each `req_valid` cycle yields exactly one `res_valid` cycle on the next clock edge. Back-to-back requests are accepted every cycle.
- R10: Kinds 6 and 7 are reserved. They are not taken, raise no fault and write no count. `res_taken`, `cnt_we` and `gp_fault` are high only while `res_valid` is high.
- R11: While reset is active, and after it, `res_valid`, `res_taken`, `cnt_we` and `gp_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | 0 jump, 1 conditional, 2 count-zero, 3 loop, 4 loop-if-equal, 5 loop-if-not-equal |
| req_cond | input | 4 | Condition code for kind 1 |
| cur_ip | input | 16 | Address of the next instruction |
| disp | input | 16 | Displacement, two's complement |
| flag_of | input | 1 | Overflow flag |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_pf | input | 1 | Parity flag |
| cnt_in | input | 32 | Current count register |
| addr32 | input | 1 | Address size is 32 bits |
| cs_limit | input | 32 | Scaled code-segment limit |
| res_valid | output | 1 | Result strobe |
| res_taken | output | 1 | Transfer taken |
| res_ip | output | 16 | Instruction pointer to continue from |
| cnt_out | output | 32 | Updated count value |
| cnt_we | output | 1 | Count write enable |
| gp_fault | output | 1 | General-protection fault request, error code 0 |

## Verification
The properties assume that the request inputs are stable only in the cycle where `req_valid` is high, and that `cs_limit` is at least 16 bits wide. The properties that use `$past` on `cur_ip`, `cnt_in` and `cs_limit` refer to that request cycle. The bench changes every request field on the falling edge, holds it through exactly one rising edge, and keeps `req_valid` low during reset. The count-change property also assumes that a loop always changes the count; a decrement always does, including the wrap from zero.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  typedef enum logic [2:0] {
    XK_JUMP   = 3'd0,
    XK_COND   = 3'd1,
    XK_CNTZ   = 3'd2,
    XK_LOOP   = 3'd3,
    XK_LOOPZ  = 3'd4,
    XK_LOOPNZ = 3'd5
  } xfer_kind_e;

  typedef struct packed {
    logic of;
    logic cf;
    logic zf;
    logic sf;
    logic pf;
  } arith_flags_t;

  localparam int unsigned COND_W = 4;
  localparam int unsigned TEST_N = 8;
endpackage

// File: rtl/nbr_rst_sync.sv
module nbr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/nbr_cond_eval.sv
module nbr_cond_eval
  import nbr_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  arith_flags_t      flags,
  output logic              hit
);
  logic [TEST_N-1:0] base_test;
  logic              less_than;

  always_comb begin
    less_than    = flags.sf ^ flags.of;
    base_test[0] = flags.of;
    base_test[1] = flags.cf;
    base_test[2] = flags.zf;
    base_test[3] = flags.cf | flags.zf;
    base_test[4] = flags.sf;
    base_test[5] = flags.pf;
    base_test[6] = less_than;
    base_test[7] = flags.zf | less_than;
    hit          = base_test[cond[COND_W-1:1]] ^ cond[0];
  end
endmodule

// File: rtl/nbr_count_unit.sv
module nbr_count_unit #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SHORT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             wide,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             dec_zero,
  output logic             cur_zero
);
  logic [SHORT_W-1:0] short_dec;
  logic [CNT_W-1:0]   wide_dec;

  assign short_dec = cnt_in[SHORT_W-1:0] - 1'b1;
  assign wide_dec  = cnt_in - 1'b1;

  generate
    if (CNT_W > SHORT_W) begin : g_split
      always_comb begin
        if (wide) begin
          cnt_dec  = wide_dec;
          dec_zero = (wide_dec == '0);
          cur_zero = (cnt_in == '0);
        end else begin
          cnt_dec  = {cnt_in[CNT_W-1:SHORT_W], short_dec};
          dec_zero = (short_dec == '0);
          cur_zero = (cnt_in[SHORT_W-1:0] == '0);
        end
      end
    end else begin : g_flat
      logic unused_wide;
      assign unused_wide = wide;
      always_comb begin
        cnt_dec  = wide_dec;
        dec_zero = (wide_dec == '0);
        cur_zero = (cnt_in == '0);
      end
    end
  endgenerate
endmodule

// File: rtl/nbr_target.sv
module nbr_target #(
  parameter int unsigned IP_W  = 16,
  parameter int unsigned LIM_W = 32
) (
  input  logic [IP_W-1:0]  cur_ip,
  input  logic [IP_W-1:0]  disp,
  input  logic [LIM_W-1:0] limit,
  output logic [IP_W-1:0]  target,
  output logic             over_limit
);
  localparam int unsigned PAD_W = LIM_W - IP_W;

  always_comb begin
    target     = cur_ip + disp;
    over_limit = ({{PAD_W{1'b0}}, target} > limit);
  end
endmodule

// File: rtl/near_branch_resolver.sv
module near_branch_resolver
  import nbr_pkg::*;
#(
  parameter int unsigned IP_W    = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned LIM_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [COND_W-1:0] req_cond,
  input  logic [IP_W-1:0]   cur_ip,
  input  logic [IP_W-1:0]   disp,
  input  logic              flag_of,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_sf,
  input  logic              flag_pf,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              addr32,
  input  logic [LIM_W-1:0]  cs_limit,
  output logic              res_valid,
  output logic              res_taken,
  output logic [IP_W-1:0]   res_ip,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              cnt_we,
  output logic              gp_fault
);
  logic             rst_i_n;
  arith_flags_t     flags;
  logic             cond_hit;
  logic [CNT_W-1:0] cnt_dec;
  logic             dec_zero, cur_zero;
  logic [IP_W-1:0]  target;
  logic             over_limit;

  logic             want_take, is_loop;
  logic             fault_d, taken_d, we_d;
  logic [IP_W-1:0]  ip_d;

  assign flags = '{of: flag_of, cf: flag_cf, zf: flag_zf, sf: flag_sf, pf: flag_pf};

  nbr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  nbr_cond_eval u_cond (
    .cond(req_cond), .flags(flags), .hit(cond_hit)
  );

  nbr_count_unit #(.CNT_W(CNT_W), .SHORT_W(SHORT_W)) u_cnt (
    .cnt_in(cnt_in), .wide(addr32), .cnt_dec(cnt_dec),
    .dec_zero(dec_zero), .cur_zero(cur_zero)
  );

  nbr_target #(.IP_W(IP_W), .LIM_W(LIM_W)) u_tgt (
    .cur_ip(cur_ip), .disp(disp), .limit(cs_limit),
    .target(target), .over_limit(over_limit)
  );

  // next-state logic
  always_comb begin
    want_take = 1'b0;
    is_loop   = 1'b0;
    unique case (req_kind)
      XK_JUMP:   want_take = 1'b1;
      XK_COND:   want_take = cond_hit;
      XK_CNTZ:   want_take = cur_zero;
      XK_LOOP: begin
        is_loop   = 1'b1;
        want_take = !dec_zero;
      end
      XK_LOOPZ: begin
        is_loop   = 1'b1;
        want_take = !dec_zero && flags.zf;
      end
      XK_LOOPNZ: begin
        is_loop   = 1'b1;
        want_take = !dec_zero && !flags.zf;
      end
      default: ;
    endcase
    fault_d = want_take && over_limit;
    taken_d = want_take && !fault_d;
    we_d    = is_loop && !fault_d;
    ip_d    = taken_d ? target : cur_ip;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_valid <= 1'b0;
      res_taken <= 1'b0;
      cnt_we    <= 1'b0;
      gp_fault  <= 1'b0;
      res_ip    <= '0;
      cnt_out   <= '0;
    end else begin
      res_valid <= req_valid;
      res_taken <= req_valid && taken_d;
      cnt_we    <= req_valid && we_d;
      gp_fault  <= req_valid && fault_d;
      if (req_valid) begin
        res_ip  <= ip_d;
        cnt_out <= cnt_dec;
      end
    end
  end

  // R9: one result per request, on the next edge
  a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |=> res_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_i_n)
    !req_valid |=> !res_valid);
  // R7: a fault blocks the count write and the taken indication
  a_r7_fault_blocks: assert property (@(posedge clk) disable iff (!rst_i_n)
    gp_fault |-> (!cnt_we && !res_taken));
  // R2: any taken result lies within the limit seen with the request
  a_r2_taken_in_limit: assert property (@(posedge clk) disable iff (!rst_i_n)
    res_taken |-> (LIM_W'(res_ip) <= $past(cs_limit)));
  // R8: a result that is not taken keeps the request pointer
  a_r8_hold_ip: assert property (@(posedge clk) disable iff (!rst_i_n)
    (res_valid && !res_taken) |-> (res_ip == $past(cur_ip)));
  // R10: qualifiers only with a valid result
  a_r10_need_valid: assert property (@(posedge clk) disable iff (!rst_i_n)
    (res_taken || cnt_we || gp_fault) |-> res_valid);
  // R6: a committed count always differs from the one presented
  a_r6_count_moves: assert property (@(posedge clk) disable iff (!rst_i_n)
    cnt_we |-> (cnt_out != $past(cnt_in)));
endmodule

// File: tb/test_near_branch_resolver.sv
module test_near_branch_resolver;
  typedef struct packed {
    logic [2:0]  kind;
    logic [3:0]  cond;
    logic [4:0]  flg;   // {of,cf,zf,sf,pf}
    logic        a32;
    logic [15:0] ip;
    logic [15:0] disp;
    logic [31:0] cnt;
    logic [31:0] lim;
    logic        e_tk;
    logic        e_gp;
    logic [15:0] e_ip;
    logic        e_we;
    logic [31:0] e_cnt;
  } vec_t;

  localparam int NV = 38;
  localparam logic [31:0] LF = 32'h0000FFFF;
  localparam vec_t TBL [NV] = '{
    // R1 jumps, wrap both ways
    '{3'd0,4'h0,5'b00000,1'b0,16'h1000,16'h0010,32'h0,LF,1'b1,1'b0,16'h1010,1'b0,32'h0},
    '{3'd0,4'h0,5'b00000,1'b0,16'hFFF0,16'h0020,32'h0,LF,1'b1,1'b0,16'h0010,1'b0,32'h0},
    '{3'd0,4'h0,5'b00000,1'b0,16'h0100,16'hFFF0,32'h0,LF,1'b1,1'b0,16'h00F0,1'b0,32'h0},
    // R3 all sixteen condition codes
    '{3'd1,4'h4,5'b00100,1'b0,16'h2000,16'h0004,32'h0,LF,1'b1,1'b0,16'h2004,1'b0,32'h0},
    '{3'd1,4'h5,5'b00100,1'b0,16'h2000,16'h0004,32'h0,LF,1'b0,1'b0,16'h2000,1'b0,32'h0},
    '{3'd1,4'hC,5'b00010,1'b0,16'h3000,16'h0100,32'h0,LF,1'b1,1'b0,16'h3100,1'b0,32'h0},
    '{3'd1,4'hD,5'b10010,1'b0,16'h3000,16'h0002,32'h0,LF,1'b1,1'b0,16'h3002,1'b0,32'h0},
    '{3'd1,4'hE,5'b10010,1'b0,16'h3000,16'h0002,32'h0,LF,1'b0,1'b0,16'h3000,1'b0,32'h0},
    '{3'd1,4'h6,5'b01000,1'b0,16'h4000,16'h0008,32'h0,LF,1'b1,1'b0,16'h4008,1'b0,32'h0},
    '{3'd1,4'h7,5'b00000,1'b0,16'h4000,16'h0010,32'h0,LF,1'b1,1'b0,16'h4010,1'b0,32'h0},
    '{3'd1,4'hA,5'b00000,1'b0,16'h5000,16'h0001,32'h0,LF,1'b0,1'b0,16'h5000,1'b0,32'h0},
    '{3'd1,4'hB,5'b00000,1'b0,16'h5000,16'h0001,32'h0,LF,1'b1,1'b0,16'h5001,1'b0,32'h0},
    '{3'd1,4'h0,5'b10000,1'b0,16'h6000,16'h0006,32'h0,LF,1'b1,1'b0,16'h6006,1'b0,32'h0},
    '{3'd1,4'h1,5'b10000,1'b0,16'h6000,16'h0006,32'h0,LF,1'b0,1'b0,16'h6000,1'b0,32'h0},
    '{3'd1,4'h8,5'b00000,1'b0,16'h6000,16'h0006,32'h0,LF,1'b0,1'b0,16'h6000,1'b0,32'h0},
    '{3'd1,4'h9,5'b00000,1'b0,16'h6000,16'h0006,32'h0,LF,1'b1,1'b0,16'h6006,1'b0,32'h0},
    '{3'd1,4'h2,5'b01000,1'b0,16'h6000,16'h0006,32'h0,LF,1'b1,1'b0,16'h6006,1'b0,32'h0},
    '{3'd1,4'h3,5'b01000,1'b0,16'h6000,16'h0006,32'h0,LF,1'b0,1'b0,16'h6000,1'b0,32'h0},
    '{3'd1,4'hF,5'b00100,1'b0,16'h6000,16'h0006,32'h0,LF,1'b0,1'b0,16'h6000,1'b0,32'h0},
    // R4 count-zero, 16 and 32 bit
    '{3'd2,4'h0,5'b00000,1'b0,16'h7000,16'h0020,32'hABCD0000,LF,1'b1,1'b0,16'h7020,1'b0,32'h0},
    '{3'd2,4'h0,5'b00000,1'b1,16'h7000,16'h0020,32'hABCD0000,LF,1'b0,1'b0,16'h7000,1'b0,32'h0},
    // R5/R6 loops
    '{3'd3,4'h0,5'b00000,1'b0,16'h8000,16'hFFFC,32'h00010005,LF,1'b1,1'b0,16'h7FFC,1'b1,32'h00010004},
    '{3'd3,4'h0,5'b00000,1'b0,16'h8000,16'hFFFC,32'h12340001,LF,1'b0,1'b0,16'h8000,1'b1,32'h12340000},
    '{3'd3,4'h0,5'b00000,1'b1,16'h8000,16'hFFFC,32'h00010000,LF,1'b1,1'b0,16'h7FFC,1'b1,32'h0000FFFF},
    '{3'd3,4'h0,5'b00000,1'b0,16'h8000,16'hFFFC,32'h00010000,LF,1'b1,1'b0,16'h7FFC,1'b1,32'h0001FFFF},
    '{3'd3,4'h0,5'b00000,1'b1,16'h8000,16'hFFFC,32'h00000001,LF,1'b0,1'b0,16'h8000,1'b1,32'h00000000},
    '{3'd4,4'h0,5'b00000,1'b1,16'h8000,16'hFFFC,32'h00000005,LF,1'b0,1'b0,16'h8000,1'b1,32'h00000004},
    '{3'd4,4'h0,5'b00100,1'b1,16'h8000,16'hFFFC,32'h00000005,LF,1'b1,1'b0,16'h7FFC,1'b1,32'h00000004},
    '{3'd5,4'h0,5'b00100,1'b1,16'h8000,16'hFFFC,32'h00000005,LF,1'b0,1'b0,16'h8000,1'b1,32'h00000004},
    '{3'd5,4'h0,5'b00000,1'b1,16'h8000,16'hFFFC,32'h00000005,LF,1'b1,1'b0,16'h7FFC,1'b1,32'h00000004},
    // R2 limit: one over, exactly at
    '{3'd0,4'h0,5'b00000,1'b0,16'h1000,16'h0100,32'h0,32'h10FF,1'b0,1'b1,16'h1000,1'b0,32'h0},
    '{3'd0,4'h0,5'b00000,1'b0,16'h1000,16'h00FF,32'h0,32'h10FF,1'b1,1'b0,16'h10FF,1'b0,32'h0},
    // R7 faulting loop
    '{3'd3,4'h0,5'b00000,1'b0,16'h1000,16'h0010,32'h00000003,32'h0FFF,1'b0,1'b1,16'h1000,1'b0,32'h0},
    // R8 not taken, target over limit
    '{3'd1,4'h4,5'b00000,1'b0,16'h1000,16'h0100,32'h0,32'h0FFF,1'b0,1'b0,16'h1000,1'b0,32'h0},
    // R10 reserved kinds
    '{3'd7,4'h0,5'b11111,1'b0,16'h1000,16'h0010,32'h00000000,LF,1'b0,1'b0,16'h1000,1'b0,32'h0},
    '{3'd6,4'h0,5'b00000,1'b0,16'h1000,16'h0010,32'h00000000,LF,1'b0,1'b0,16'h1000,1'b0,32'h0},
    // R6 32-bit wrap from zero
    '{3'd3,4'h0,5'b00000,1'b1,16'h8000,16'hFFFC,32'h00000000,LF,1'b1,1'b0,16'h7FFC,1'b1,32'hFFFFFFFF},
    // R2 count-zero jump that faults
    '{3'd2,4'h0,5'b00000,1'b0,16'h1000,16'h0100,32'h00000000,32'h0FFF,1'b0,1'b1,16'h1000,1'b0,32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [3:0]  req_cond;
  logic [15:0] cur_ip, disp;
  logic        flag_of, flag_cf, flag_zf, flag_sf, flag_pf;
  logic [31:0] cnt_in, cs_limit;
  logic        addr32;
  logic        res_valid, res_taken, cnt_we, gp_fault;
  logic [15:0] res_ip;
  logic [31:0] cnt_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  near_branch_resolver i_near_branch_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_cond(req_cond), .cur_ip(cur_ip), .disp(disp),
    .flag_of(flag_of), .flag_cf(flag_cf), .flag_zf(flag_zf),
    .flag_sf(flag_sf), .flag_pf(flag_pf), .cnt_in(cnt_in), .addr32(addr32),
    .cs_limit(cs_limit), .res_valid(res_valid), .res_taken(res_taken),
    .res_ip(res_ip), .cnt_out(cnt_out), .cnt_we(cnt_we), .gp_fault(gp_fault)
  );

  function automatic string tag_of(vec_t v);
    if (v.e_gp && v.kind >= 3'd3 && v.kind <= 3'd5) return "R7";
    if (v.e_gp) return "R2";
    if (v.kind > 3'd5) return "R10";
    if (!v.e_tk && v.kind == 3'd1) return "R3/R8";
    if (v.kind == 3'd0) return "R1";
    if (v.kind == 3'd1) return "R3";
    if (v.kind == 3'd2) return "R4";
    if (v.a32 == 1'b0) return "R5/R6";
    return "R5";
  endfunction

  task automatic drive(vec_t v);
    req_valid = 1'b1;
    req_kind  = v.kind;
    req_cond  = v.cond;
    {flag_of, flag_cf, flag_zf, flag_sf, flag_pf} = v.flg;
    addr32    = v.a32;
    cur_ip    = v.ip;
    disp      = v.disp;
    cnt_in    = v.cnt;
    cs_limit  = v.lim;
  endtask

  task automatic check_vec(int idx, vec_t v);
    bit bad;
    checks++;
    bad = (res_valid !== 1'b1) || (res_taken !== v.e_tk) || (gp_fault !== v.e_gp) ||
          (res_ip !== v.e_ip) || (cnt_we !== v.e_we) ||
          (v.e_we && (cnt_out !== v.e_cnt));
    if (bad) begin
      errors++;
      $display("FAIL %s vec %0d: got v=%b tk=%b gp=%b ip=%h we=%b cnt=%h exp tk=%b gp=%b ip=%h we=%b cnt=%h",
               tag_of(v), idx, res_valid, res_taken, gp_fault, res_ip, cnt_we, cnt_out,
               v.e_tk, v.e_gp, v.e_ip, v.e_we, v.e_cnt);
    end
  endtask

  task automatic check_idle(string tag);
    checks++;
    if (res_valid !== 1'b0 || res_taken !== 1'b0 || cnt_we !== 1'b0 || gp_fault !== 1'b0) begin
      errors++;
      $display("FAIL %s: got v=%b tk=%b we=%b gp=%b exp all 0",
               tag, res_valid, res_taken, cnt_we, gp_fault);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    drive(TBL[0]);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R11 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R11 after reset");

    // table walk, requests back to back (R9)
    drive(TBL[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check_vec(i, TBL[i]);
      if (i + 1 < NV) drive(TBL[i + 1]);
      else req_valid = 1'b0;
    end
    @(negedge clk);
    check_idle("R9 no result without request");

    // R10: idle cycles after a faulting loop drop all qualifiers
    drive(TBL[32]);
    @(negedge clk);
    check_vec(32, TBL[32]);
    req_valid = 1'b0;
    @(negedge clk);
    check_idle("R10 qualifiers cleared when idle");

    // R9: isolated request gives one result cycle only
    drive(TBL[21]);
    @(negedge clk);
    check_vec(21, TBL[21]);
    req_valid = 1'b0;
    @(negedge clk);
    check_idle("R9 single result cycle");

    // R11: reset with a taken result pending
    drive(TBL[29]);
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    #1;
    check_idle("R11 reset clears pending result");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R11 idle after second reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule